// File: doc/BRIEF.md
# Display FIFO Refill Request Generator

This block sits beside the output FIFOs of a video display port. It compares each FIFO's free space, counted in doublewords, against a programmable threshold. When there is enough room, it sends a one-cycle event to a DMA engine so that the engine refills that FIFO. Each video field has its own threshold, and the current field selects which one is active.

In separated luma/chroma operation, three FIFOs are served. The Y FIFO is compared against the full threshold. The two chroma FIFOs (Cb, Cr) are compared against half of it, truncated. In raw data operation only the single display FIFO is served, through the Y event, and the chroma events are silent.

After a FIFO has been requested, it is not requested again until the DMA engine acknowledges delivery. The block also keeps a frame pixel counter. In raw operation it advances once every programmable number of output clocks. In luma/chroma operation it advances on every output clock. It clears at each frame start.

Top module: `disp_dma_req`

## Requirements
- R1: After reset the three events, the pixel counter and the whole register readback are 0.
- R2: A register write takes effect on the next clock. Field 1 threshold is bits 9:0, pixel step count is bits 15:12, field 2 threshold is bits 25:16. Readback returns those fields, and bits 31:26 and 11:10 always read 0.
- R3: With `field_sel` = 0 the field 1 threshold is active; with `field_sel` = 1 the field 2 threshold is active.
- R4: `y_evt` is high for exactly one cycle, in the cycle after a clock edge at which the Y free space was at least the active threshold and the Y FIFO was not awaiting service.
- R5: In luma/chroma mode (`raw_mode` = 0), `cb_evt`/`cr_evt` follow the same rule using that FIFO's space against the active threshold shifted right by one (truncated).
- R6: In raw mode (`raw_mode` = 1), `cb_evt` and `cr_evt` stay 0 whatever the chroma spaces; `y_evt` still follows R4.
- R7: Once a FIFO has raised an event, it raises no further event until its acknowledge has been seen at a clock edge. From the following edge it may fire again.
- R8: A threshold of 0 fires an event whenever the FIFO is not awaiting service, even with zero free space.
- R9: In raw mode the pixel counter increments once every N cycles with `out_clk_en` high, where N is the pixel step count; a step count of 0 behaves as 1.
- R10: In luma/chroma mode the pixel counter increments on every `out_clk_en` cycle, regardless of the step count.
- R11: `frame_start` clears the pixel counter and its prescaler at the next edge, taking priority over `out_clk_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 32 | Register write value |
| cfg_rd_data | output | 32 | Register readback |
| raw_mode | input | 1 | 1 = raw data mode, 0 = luma/chroma mode |
| field_sel | input | 1 | 0 = field 1 being output, 1 = field 2 |
| out_clk_en | input | 1 | Output pixel clock enable |
| frame_start | input | 1 | Start of frame, clears pixel counter |
| y_space | input | SPACE_W | Free doublewords in Y (or raw) FIFO |
| cb_space | input | SPACE_W | Free doublewords in Cb FIFO |
| cr_space | input | SPACE_W | Free doublewords in Cr FIFO |
| y_ack | input | 1 | DMA delivered the requested Y block |
| cb_ack | input | 1 | DMA delivered the requested Cb block |
| cr_ack | input | 1 | DMA delivered the requested Cr block |
| y_evt | output | 1 | Y refill event pulse |
| cb_evt | output | 1 | Cb refill event pulse |
| cr_evt | output | 1 | Cr refill event pulse |
| pix_count | output | PIX_W | Frame pixel counter |

## Verification
Every result in this block is due exactly one clock edge after the inputs that cause it:
- Events appear in the cycle after the edge that sampled space, field, mode and acknowledge.
- Readback shows a write one edge later.
- The pixel counter moves at the edge that sees `out_clk_en` or `frame_start`.

The bench drives inputs and samples outputs 2 ns after each rising edge. A reference model in the bench is advanced at that same edge from the inputs held across it, so each comparison lines up with the single register stage in the design.

// File: rtl/disp_dma_req.sv
module disp_dma_req #(
  parameter int SPACE_W = 11,
  parameter int THR_W   = 10,
  parameter int INC_W   = 4,
  parameter int PIX_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [31:0]        cfg_wr_data,
  output logic [31:0]        cfg_rd_data,
  input  logic               raw_mode,
  input  logic               field_sel,
  input  logic               out_clk_en,
  input  logic               frame_start,
  input  logic [SPACE_W-1:0] y_space,
  input  logic [SPACE_W-1:0] cb_space,
  input  logic [SPACE_W-1:0] cr_space,
  input  logic               y_ack,
  input  logic               cb_ack,
  input  logic               cr_ack,
  output logic               y_evt,
  output logic               cb_evt,
  output logic               cr_evt,
  output logic [PIX_W-1:0]   pix_count
);

  localparam int T1_LSB  = 0;
  localparam int INC_LSB = 12;
  localparam int T2_LSB  = 16;
  localparam int NF      = 3;
  localparam int CMP_W   = (SPACE_W > THR_W) ? SPACE_W : THR_W;
  localparam logic [31:0] RD_MASK = (((32'd1 << THR_W) - 32'd1) << T2_LSB)
                                  | (((32'd1 << INC_W) - 32'd1) << INC_LSB)
                                  | (((32'd1 << THR_W) - 32'd1) << T1_LSB);

  logic [THR_W-1:0] thr1_q, thr2_q;
  logic [INC_W-1:0] inc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr1_q <= '0;
      thr2_q <= '0;
      inc_q  <= '0;
    end else if (cfg_wr_en) begin
      thr1_q <= cfg_wr_data[T1_LSB +: THR_W];
      thr2_q <= cfg_wr_data[T2_LSB +: THR_W];
      inc_q  <= cfg_wr_data[INC_LSB +: INC_W];
    end
  end

  always_comb begin
    cfg_rd_data = '0;
    cfg_rd_data[T1_LSB +: THR_W]  = thr1_q;
    cfg_rd_data[T2_LSB +: THR_W]  = thr2_q;
    cfg_rd_data[INC_LSB +: INC_W] = inc_q;
  end

  logic [THR_W-1:0] thr_act, thr_half;
  assign thr_act  = field_sel ? thr2_q : thr1_q;
  assign thr_half = thr_act >> 1;

  logic [NF-1:0][SPACE_W-1:0] space_v;
  logic [NF-1:0] ack_v, need, fire, pend_q, evt_q;
  assign space_v = {cr_space, cb_space, y_space};
  assign ack_v   = {cr_ack, cb_ack, y_ack};

  generate
    for (genvar g = 0; g < NF; g++) begin : g_fifo
      if (g == 0) begin : g_luma
        assign need[g] = CMP_W'(space_v[g]) >= CMP_W'(thr_act);
      end else begin : g_chroma
        assign need[g] = !raw_mode && (CMP_W'(space_v[g]) >= CMP_W'(thr_half));
      end
    end
  endgenerate

  assign fire = need & ~pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      evt_q  <= '0;
    end else begin
      pend_q <= fire | (pend_q & ~ack_v);
      evt_q  <= fire;
    end
  end

  assign {cr_evt, cb_evt, y_evt} = evt_q;

  logic [INC_W-1:0] pre_q;
  logic [PIX_W-1:0] pix_q;
  logic             tick;
  assign tick = ({1'b0, pre_q} + (INC_W+1)'(1)) >= {1'b0, inc_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      pix_q <= '0;
    end else if (frame_start) begin
      pre_q <= '0;
      pix_q <= '0;
    end else if (out_clk_en) begin
      if (raw_mode && !tick) begin
        pre_q <= pre_q + INC_W'(1);
      end else begin
        pre_q <= '0;
        pix_q <= pix_q + PIX_W'(1);
      end
    end
  end

  assign pix_count = pix_q;

  assert_reg_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> cfg_rd_data == ($past(cfg_wr_data) & RD_MASK));

  assert_y_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    y_evt |=> !y_evt);

  assert_y_needs_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(y_evt) |-> $past(CMP_W'(y_space) >= CMP_W'(thr_act)));

  assert_raw_chroma_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    raw_mode |=> !cb_evt && !cr_evt);

  assert_zero_thr_fires_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_act == '0) && !pend_q[0] |=> y_evt);

  assert_frame_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> pix_count == '0);

  assert_yc_pix_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_mode && out_clk_en && !frame_start |=> pix_count == $past(pix_count) + PIX_W'(1));

  assert_raw_unit_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    raw_mode && out_clk_en && !frame_start && (inc_q <= INC_W'(1))
    |=> pix_count == $past(pix_count) + PIX_W'(1));

endmodule

// File: tb/disp_dma_req_tb_top.sv
module disp_dma_req_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr_en = 0;
  logic [31:0] cfg_wr_data = 0;
  logic [31:0] cfg_rd_data;
  logic        raw_mode = 0, field_sel = 0, out_clk_en = 0, frame_start = 0;
  logic [10:0] y_space = 0, cb_space = 0, cr_space = 0;
  logic        y_ack = 0, cb_ack = 0, cr_ack = 0;
  logic        y_evt, cb_evt, cr_evt;
  logic [15:0] pix_count;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  disp_dma_req dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .raw_mode(raw_mode), .field_sel(field_sel),
    .out_clk_en(out_clk_en), .frame_start(frame_start), .y_space(y_space),
    .cb_space(cb_space), .cr_space(cr_space), .y_ack(y_ack), .cb_ack(cb_ack),
    .cr_ack(cr_ack), .y_evt(y_evt), .cb_evt(cb_evt), .cr_evt(cr_evt),
    .pix_count(pix_count)
  );

  logic [9:0]  m_t1 = 0, m_t2 = 0;
  logic [3:0]  m_inc = 0, m_pre = 0;
  logic [2:0]  m_pend = 0, m_evt = 0;
  logic [15:0] m_pix = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_rd();
    return {6'b0, m_t2, m_inc, 2'b0, m_t1};
  endfunction

  task automatic model_update();
    int thr, lim;
    int sp[3];
    logic [2:0] ack, ne, np;
    logic cond, f;
    sp[0] = y_space; sp[1] = cb_space; sp[2] = cr_space;
    ack = {cr_ack, cb_ack, y_ack};
    thr = field_sel ? m_t2 : m_t1;
    for (int i = 0; i < 3; i++) begin
      lim  = (i == 0) ? thr : thr / 2;
      cond = (sp[i] >= lim) && (i == 0 || !raw_mode);
      f    = !m_pend[i] && cond;
      ne[i] = f;
      np[i] = f || (m_pend[i] && !ack[i]);
    end
    m_evt = ne;
    m_pend = np;
    if (frame_start) begin
      m_pre = 0; m_pix = 0;
    end else if (out_clk_en) begin
      if (!raw_mode) begin
        m_pre = 0; m_pix = m_pix + 1;
      end else if (int'(m_pre) + 1 >= int'(m_inc)) begin
        m_pre = 0; m_pix = m_pix + 1;
      end else begin
        m_pre = m_pre + 1;
      end
    end
    if (cfg_wr_en) begin
      m_t1 = cfg_wr_data[9:0]; m_t2 = cfg_wr_data[25:16]; m_inc = cfg_wr_data[15:12];
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    #2;
    chk("R4 y_evt model", {31'b0, y_evt}, {31'b0, m_evt[0]});
    chk(raw_mode ? "R6 cb_evt model" : "R5 cb_evt model", {31'b0, cb_evt}, {31'b0, m_evt[1]});
    chk(raw_mode ? "R6 cr_evt model" : "R5 cr_evt model", {31'b0, cr_evt}, {31'b0, m_evt[2]});
    chk(raw_mode ? "R9 pix model" : "R10 pix model", {16'b0, pix_count}, {16'b0, m_pix});
    chk("R2 readback model", cfg_rd_data, m_rd());
  endtask

  task automatic wr(input logic [9:0] t2, input logic [3:0] inc, input logic [9:0] t1);
    cfg_wr_en = 1;
    cfg_wr_data = {6'h3F, t2, inc, 2'b11, t1};
    step();
    cfg_wr_en = 0;
  endtask

  task automatic clear_pend();
    y_space = 0; cb_space = 0; cr_space = 0;
    y_ack = 1; cb_ack = 1; cr_ack = 1;
    step();
    y_ack = 0; cb_ack = 0; cr_ack = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1;
    chk("R1 reset y_evt", {31'b0, y_evt}, 0);
    chk("R1 reset cb/cr", {30'b0, cb_evt, cr_evt}, 0);
    chk("R1 reset pix", {16'b0, pix_count}, 0);
    chk("R1 reset readback", cfg_rd_data, 0);

    wr(10'd40, 4'd3, 10'd20);
    chk("R2 readback masks reserved", cfg_rd_data, {6'b0, 10'd40, 4'd3, 2'b0, 10'd20});
    clear_pend();

    y_space = 19; step();
    chk("R4 below threshold", {31'b0, y_evt}, 0);
    y_space = 20; step();
    chk("R4 at threshold", {31'b0, y_evt}, 1);
    step();
    chk("R7 no repeat while pending", {31'b0, y_evt}, 0);
    y_ack = 1; step();
    chk("R7 ack edge no fire", {31'b0, y_evt}, 0);
    y_ack = 0; step();
    chk("R7 fires after ack", {31'b0, y_evt}, 1);

    clear_pend();
    field_sel = 1; y_space = 39; step();
    chk("R3 field2 below", {31'b0, y_evt}, 0);
    y_space = 40; step();
    chk("R3 field2 at", {31'b0, y_evt}, 1);

    clear_pend();
    field_sel = 0; cb_space = 9; cr_space = 10; step();
    chk("R5 cb below half", {31'b0, cb_evt}, 0);
    chk("R5 cr at half", {31'b0, cr_evt}, 1);
    wr(10'd40, 4'd3, 10'd21);
    clear_pend();
    cb_space = 10; step();
    chk("R5 odd threshold truncates", {31'b0, cb_evt}, 1);

    clear_pend();
    raw_mode = 1; y_space = 11'h7FF; cb_space = 11'h7FF; cr_space = 11'h7FF;
    step();
    chk("R6 raw y fires", {31'b0, y_evt}, 1);
    for (int k = 0; k < 3; k++) begin
      chk("R6 raw chroma silent", {30'b0, cb_evt, cr_evt}, 0);
      step();
    end
    raw_mode = 0;

    clear_pend();
    wr(10'd40, 4'd3, 10'd0);
    step();
    chk("R8 zero threshold y", {31'b0, y_evt}, 1);
    chk("R8 zero threshold chroma", {30'b0, cb_evt, cr_evt}, 2'b11);
    wr(10'd40, 4'd3, 10'd20);
    clear_pend();

    raw_mode = 1;
    frame_start = 1; out_clk_en = 1; step(); frame_start = 0;
    chk("R11 frame start clears", {16'b0, pix_count}, 0);
    for (int k = 0; k < 6; k++) step();
    chk("R9 step three", {16'b0, pix_count}, 2);
    out_clk_en = 0;
    wr(10'd40, 4'd0, 10'd20);
    frame_start = 1; step(); frame_start = 0;
    out_clk_en = 1;
    for (int k = 0; k < 4; k++) step();
    chk("R9 step zero as one", {16'b0, pix_count}, 4);
    out_clk_en = 0;
    raw_mode = 0;
    wr(10'd40, 4'd3, 10'd20);
    frame_start = 1; step(); frame_start = 0;
    out_clk_en = 1;
    for (int k = 0; k < 5; k++) step();
    chk("R10 step ignored", {16'b0, pix_count}, 5);
    frame_start = 1; step(); frame_start = 0; out_clk_en = 0;
    chk("R11 clears over enable", {16'b0, pix_count}, 0);

    for (int n = 0; n < 4000; n++) begin
      y_space  = 11'($urandom_range(0, 60));
      cb_space = 11'($urandom_range(0, 40));
      cr_space = 11'($urandom_range(0, 40));
      y_ack  = ($urandom_range(0, 3) == 0);
      cb_ack = ($urandom_range(0, 3) == 0);
      cr_ack = ($urandom_range(0, 3) == 0);
      out_clk_en  = $urandom_range(0, 1);
      frame_start = ($urandom_range(0, 63) == 0);
      if ($urandom_range(0, 31) == 0) field_sel = ~field_sel;
      if ($urandom_range(0, 199) == 0) raw_mode = ~raw_mode;
      cfg_wr_en = ($urandom_range(0, 49) == 0);
      cfg_wr_data = $urandom;
      cfg_wr_data[25:16] = 10'($urandom_range(0, 60));
      cfg_wr_data[9:0]   = 10'($urandom_range(0, 60));
      step();
    end
    cfg_wr_en = 0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule